// File: doc/BRIEF.md
# Time-Shared Radix-2 FFT Engine

This block computes a 64-point complex forward FFT with a single radix-2 decimation-in-time butterfly that is reused for every one of the 192 butterfly operations. Samples arrive on a valid/ready stream and are scattered into a working memory at bit-reversed addresses. Once the 64th sample is taken, a sequencer walks six stages of 32 butterflies. Each butterfly reads its operand pair and a coefficient from a computed twiddle table. It forms the twiddle product with four parallel 8x8 multiplies, then the sum and the difference at 16 bits. It keeps the top 8 bits of each result and writes them to a second memory. At the end of every stage the second memory is copied back into the working one.

When the last stage finishes, a one-cycle completion pulse is raised and the 64 frequency bins are offered on an output valid/ready stream in natural order, bin 0 first. The input side refuses data (ready low) from the moment a frame is complete until the last bin has been taken. Output back-pressure is honoured: while valid is high and ready is low, the presented bin holds. Both streams transfer one item on each rising clock edge at which valid and ready are both high.

Top module: `fft_radix2_core`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: The input accepts exactly 64 samples per frame. The cycle after the 64th accepted sample, in_ready is 0. It returns to 1 the cycle after the 64th output transfer.
- R3: While a frame is being transformed or drained, in_ready stays 0 and out-of-turn in_valid activity has no effect on the results.
- R4: Each butterfly produces X = A·2^7 + W·B and Y = A·2^7 − W·B. Both are formed at 16 bits with two's-complement wrap and no overflow detection. The stored value is bits [15:8] of each, so it is floored.
- R5: Twiddle W_k for k in 0..63 has real part round(127·cos(2πk/64)) and imaginary part round(−127·sin(2πk/64)), rounding half away from zero. Stage s (0..5), butterfly j uses offset 2^s and W with k = (j mod 2^s)·2^(5−s).
- R6: Input sample n is stored at the 6-bit bit-reversal of n, for example 6 → 24. Output bins come out in natural order 0..63.
- R7: done is high for exactly one cycle, and that cycle is the first cycle of out_valid.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_re and out_im hold. After the 64th output transfer, out_valid is 0.
- R9: done rises 6·(32·4+64) = 1152 clock cycles after the edge that accepts the 64th sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine can take a sample |
| in_re | input | 8 | Sample real part, signed |
| in_im | input | 8 | Sample imaginary part, signed |
| out_valid | output | 1 | Bin presented |
| out_ready | input | 1 | Consumer takes the bin |
| out_re | output | 8 | Bin real part, signed |
| out_im | output | 8 | Bin imaginary part, signed |
| done | output | 1 | One-cycle transform-complete pulse |

## Verification
Draining results under back-pressure and refusing a new load can happen in the same cycle: the output stream stalls while in_valid is held high with junk data. The bench provokes this by keeping in_valid asserted from the end of each selected frame until its last bin leaves, while out_ready follows an irregular stall pattern. It judges the outcome by three things: in_ready stays low throughout, every stalled bin holds its value, and all 64 bins still match the fixed-point reference. It then checks that the next frame loads cleanly.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic [2:0] {
    ST_FILL   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_MUL    = 3'd2,
    ST_ADDSUB = 3'd3,
    ST_WRITE  = 3'd4,
    ST_COPY   = 3'd5,
    ST_DRAIN  = 3'd6
  } fft_state_e;

  // Q7 magnitude of cos(2*pi*i/64) for the first quarter turn, i = 0..16
  function automatic logic [6:0] quarter_cos(input logic [4:0] i);
    logic [6:0] m;
    case (i)
      5'd0:  m = 7'd127;
      5'd1:  m = 7'd126;
      5'd2:  m = 7'd125;
      5'd3:  m = 7'd122;
      5'd4:  m = 7'd117;
      5'd5:  m = 7'd112;
      5'd6:  m = 7'd106;
      5'd7:  m = 7'd98;
      5'd8:  m = 7'd90;
      5'd9:  m = 7'd81;
      5'd10: m = 7'd71;
      5'd11: m = 7'd60;
      5'd12: m = 7'd49;
      5'd13: m = 7'd37;
      5'd14: m = 7'd25;
      5'd15: m = 7'd12;
      default: m = 7'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fft_agu.sv
module fft_agu #(
  parameter int LOG2N = 6,
  localparam int AW = LOG2N,
  localparam int SW = $clog2(LOG2N),
  localparam int BW = LOG2N - 1
) (
  input  logic [SW-1:0] stage,
  input  logic [BW-1:0] bfly,
  output logic [AW-1:0] addr_p,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] tw_idx
);
  logic [AW-1:0] bf_w, half, pos, grp_base;

  assign bf_w     = {1'b0, bfly};
  assign half     = AW'(1) << stage;
  assign pos      = bf_w & (half - AW'(1));
  assign grp_base = (bf_w >> stage) << (stage + 1'b1);
  assign addr_p   = grp_base | pos;
  assign addr_q   = addr_p | half;
  assign tw_idx   = pos << (AW'(LOG2N - 1) - AW'(stage));
endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
  import fft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG2N  = 6
) (
  input  logic [LOG2N-1:0]         k,
  output logic signed [DATA_W-1:0] w_re,
  output logic signed [DATA_W-1:0] w_im
);
  localparam int SH = DATA_W - 8;

  logic [5:0] k64;
  logic [4:0] r, r_c;
  logic signed [DATA_W-1:0] m_r, m_c, cos_v, sin_v;

  assign k64 = 6'(k) << (6 - LOG2N);
  assign r   = {1'b0, k64[3:0]};
  assign r_c = 5'd16 - r;
  assign m_r = DATA_W'(quarter_cos(r)) <<< SH;
  assign m_c = DATA_W'(quarter_cos(r_c)) <<< SH;

  always_comb begin
    unique case (k64[5:4])
      2'd0: begin cos_v =  m_r; sin_v =  m_c; end
      2'd1: begin cos_v = -m_c; sin_v =  m_r; end
      2'd2: begin cos_v = -m_r; sin_v = -m_c; end
      default: begin cos_v = m_c; sin_v = -m_r; end
    endcase
  end

  assign w_re = cos_v;
  assign w_im = -sin_v;
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
  parameter int DATA_W = 8,
  localparam int PW = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     ld_op,
  input  logic                     ld_mul,
  input  logic                     ld_res,
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [DATA_W-1:0] b_re,
  input  logic signed [DATA_W-1:0] b_im,
  input  logic signed [DATA_W-1:0] w_re,
  input  logic signed [DATA_W-1:0] w_im,
  output logic signed [DATA_W-1:0] x_re,
  output logic signed [DATA_W-1:0] x_im,
  output logic signed [DATA_W-1:0] y_re,
  output logic signed [DATA_W-1:0] y_im
);
  logic signed [DATA_W-1:0] op_ar, op_ai, op_br, op_bi, op_wr, op_wi;
  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [PW-1:0] p_re, p_im, a_sh_re, a_sh_im;
  logic signed [PW-1:0] xs_re, xs_im, ys_re, ys_im;

  // operand buffer
  always_ff @(posedge clk) begin
    if (ld_op) begin
      op_ar <= a_re; op_ai <= a_im;
      op_br <= b_re; op_bi <= b_im;
      op_wr <= w_re; op_wi <= w_im;
    end
  end

  // four real products in parallel
  always_ff @(posedge clk) begin
    if (ld_mul) begin
      m_rr <= PW'(op_wr) * PW'(op_br);
      m_ii <= PW'(op_wi) * PW'(op_bi);
      m_ri <= PW'(op_wr) * PW'(op_bi);
      m_ir <= PW'(op_wi) * PW'(op_br);
    end
  end

  assign p_re    = m_rr - m_ii;
  assign p_im    = m_ri + m_ir;
  assign a_sh_re = PW'(op_ar) <<< (DATA_W - 1);
  assign a_sh_im = PW'(op_ai) <<< (DATA_W - 1);
  assign xs_re   = a_sh_re + p_re;
  assign xs_im   = a_sh_im + p_im;
  assign ys_re   = a_sh_re - p_re;
  assign ys_im   = a_sh_im - p_im;

  // result buffer, upper half kept
  always_ff @(posedge clk) begin
    if (ld_res) begin
      x_re <= xs_re[PW-1:DATA_W];
      x_im <= xs_im[PW-1:DATA_W];
      y_re <= ys_re[PW-1:DATA_W];
      y_im <= ys_im[PW-1:DATA_W];
    end
  end
endmodule

// File: rtl/fft_radix2_core.sv
module fft_radix2_core
  import fft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG2N  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im,
  output logic                     done
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;
  localparam int SW = $clog2(LOG2N);
  localparam int BW = LOG2N - 1;
  localparam logic [AW-1:0] CNT_LAST   = AW'(N - 1);
  localparam logic [BW-1:0] BF_LAST    = BW'(N / 2 - 1);
  localparam logic [SW-1:0] STAGE_LAST = SW'(LOG2N - 1);

  fft_state_e state;
  logic [AW-1:0] cnt, fill_addr, addr_p, addr_q, tw_idx;
  logic [SW-1:0] stage;
  logic [BW-1:0] bfly;
  logic          done_q;

  logic signed [DATA_W-1:0] ma_re [N];
  logic signed [DATA_W-1:0] ma_im [N];
  logic signed [DATA_W-1:0] mb_re [N];
  logic signed [DATA_W-1:0] mb_im [N];

  logic signed [DATA_W-1:0] w_re, w_im, x_re, x_im, y_re, y_im;

  // bit-reversed placement of incoming samples
  for (genvar g = 0; g < AW; g++) begin : g_rev
    assign fill_addr[g] = cnt[AW-1-g];
  end

  fft_agu #(.LOG2N(LOG2N)) u_agu (
    .stage (stage),
    .bfly  (bfly),
    .addr_p(addr_p),
    .addr_q(addr_q),
    .tw_idx(tw_idx)
  );

  fft_twiddle_rom #(.DATA_W(DATA_W), .LOG2N(LOG2N)) u_rom (
    .k   (tw_idx),
    .w_re(w_re),
    .w_im(w_im)
  );

  fft_butterfly #(.DATA_W(DATA_W)) u_bfly (
    .clk   (clk),
    .ld_op (state == ST_FETCH),
    .ld_mul(state == ST_MUL),
    .ld_res(state == ST_ADDSUB),
    .a_re  (ma_re[addr_p]),
    .a_im  (ma_im[addr_p]),
    .b_re  (ma_re[addr_q]),
    .b_im  (ma_im[addr_q]),
    .w_re  (w_re),
    .w_im  (w_im),
    .x_re  (x_re),
    .x_im  (x_im),
    .y_re  (y_re),
    .y_im  (y_im)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      cnt    <= '0;
      stage  <= '0;
      bfly   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_FILL: begin
          if (in_valid) begin
            if (cnt == CNT_LAST) begin
              cnt   <= '0;
              stage <= '0;
              bfly  <= '0;
              state <= ST_FETCH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FETCH:  state <= ST_MUL;
        ST_MUL:    state <= ST_ADDSUB;
        ST_ADDSUB: state <= ST_WRITE;
        ST_WRITE: begin
          if (bfly == BF_LAST) begin
            bfly  <= '0;
            state <= ST_COPY;
          end else begin
            bfly  <= bfly + 1'b1;
            state <= ST_FETCH;
          end
        end
        ST_COPY: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (stage == STAGE_LAST) begin
              state  <= ST_DRAIN;
              done_q <= 1'b1;
            end else begin
              stage <= stage + 1'b1;
              state <= ST_FETCH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (out_ready) begin
            if (cnt == CNT_LAST) begin
              cnt   <= '0;
              state <= ST_FILL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // working memory: load and copy-back
  always_ff @(posedge clk) begin
    if (state == ST_FILL && in_valid) begin
      ma_re[fill_addr] <= in_re;
      ma_im[fill_addr] <= in_im;
    end
    if (state == ST_COPY) begin
      ma_re[cnt] <= mb_re[cnt];
      ma_im[cnt] <= mb_im[cnt];
    end
  end

  // result memory
  always_ff @(posedge clk) begin
    if (state == ST_WRITE) begin
      mb_re[addr_p] <= x_re;
      mb_im[addr_p] <= x_im;
      mb_re[addr_q] <= y_re;
      mb_im[addr_q] <= y_im;
    end
  end

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_DRAIN);
  assign out_re    = ma_re[cnt];
  assign out_im    = ma_im[cnt];
  assign done      = done_q;
endmodule

// File: rtl/fft_radix2_chk.sv
module fft_radix2_chk #(
  parameter int DATA_W = 8,
  parameter int LOG2N  = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_re,
  input logic signed [DATA_W-1:0] out_im,
  input logic                     done
);
  localparam int N   = 1 << LOG2N;
  localparam int LAT = LOG2N * ((N / 2) * 4 + N);

  logic [LOG2N-1:0] acc_cnt;
  logic [31:0]      lat_cnt;
  logic             last_acc;

  assign last_acc = in_valid && in_ready && (acc_cnt == LOG2N'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      lat_cnt <= '0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
      if (last_acc) lat_cnt <= '0;
      else          lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_acc |=> !in_ready);

  assert_no_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 32'(LAT)));
endmodule

bind fft_radix2_core fft_radix2_chk #(.DATA_W(DATA_W), .LOG2N(LOG2N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_re   (out_re),
  .out_im   (out_im),
  .done     (done)
);

// File: tb/fft_radix2_core_tb.sv
module fft_radix2_core_tb;
  localparam int DW  = 8;
  localparam int LG  = 6;
  localparam int N   = 64;
  localparam int LAT = LG * ((N / 2) * 4 + N);
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic in_ready, out_valid, done;
  logic signed [DW-1:0] out_re, out_im;

  int n_chk = 0;
  int n_bad = 0;
  int src_re [N];
  int src_im [N];
  int exp_re [N];
  int exp_im [N];

  always #5 clk = ~clk;

  fft_radix2_core #(.DATA_W(DW), .LOG2N(LG)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
    .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input int a1, input int a2, input int e1, input int e2);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=(%0d,%0d) expected=(%0d,%0d)", tag, a1, a2, e1, e2);
    end
  endtask

  function automatic int rnd(input real x);
    if (x >= 0.0) return int'($floor(x + 0.5));
    return -int'($floor(-x + 0.5));
  endfunction

  function automatic int wrap16(input int v);
    logic signed [15:0] t;
    t = 16'(v);
    return int'(t);
  endfunction

  function automatic int bitrev(input int n);
    int r = 0;
    for (int b = 0; b < LG; b++) r |= ((n >> b) & 1) << (LG - 1 - b);
    return r;
  endfunction

  // fixed-point reference following R4, R5, R6
  task automatic compute_ref();
    int ar [N];
    int ai [N];
    for (int n = 0; n < N; n++) begin
      ar[bitrev(n)] = src_re[n];
      ai[bitrev(n)] = src_im[n];
    end
    for (int s = 0; s < LG; s++) begin
      for (int j = 0; j < N / 2; j++) begin
        int half, pos, p, q, k, wr, wi, pr, pim, xr, xi, yr, yi;
        half = 1 << s;
        pos  = j & (half - 1);
        p    = ((j >> s) << (s + 1)) + pos;
        q    = p + half;
        k    = pos << (LG - 1 - s);
        wr   = rnd(127.0 * $cos(2.0 * PI * k / N));
        wi   = rnd(-127.0 * $sin(2.0 * PI * k / N));
        pr   = wrap16(wr * ar[q] - wi * ai[q]);
        pim  = wrap16(wr * ai[q] + wi * ar[q]);
        xr   = wrap16(ar[p] * 128 + pr);
        xi   = wrap16(ai[p] * 128 + pim);
        yr   = wrap16(ar[p] * 128 - pr);
        yi   = wrap16(ai[p] * 128 - pim);
        ar[p] = xr >>> 8; ai[p] = xi >>> 8;
        ar[q] = yr >>> 8; ai[q] = yi >>> 8;
      end
    end
    for (int n = 0; n < N; n++) begin
      exp_re[n] = ar[n];
      exp_im[n] = ai[n];
    end
  endtask

  // load one frame, wait for completion, drain with optional stalls and junk loads
  task automatic run_frame(input bit junk, input int stall_mode);
    int cyc, idx;
    bit prev_stall, first;
    int pv_re, pv_im;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = DW'(src_re[n]);
      in_im = DW'(src_im[n]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    check(in_ready == 1'b0, "R2 ready low after 64th sample", int'(in_ready), 0, 0, 0);
    if (junk) begin
      in_valid = 1'b1; in_re = 8'sh5A; in_im = -8'sd77;
    end else begin
      in_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    check(cyc == LAT, "R9 latency to done", cyc, 0, LAT, 0);
    check(out_valid == 1'b1, "R7 done with first out_valid", int'(out_valid), int'(done), 1, 1);
    check(in_ready == 1'b0, "R3 load refused while results pending", int'(in_ready), 0, 0, 0);
    prev_stall = 1'b1;
    pv_re = int'(out_re);
    pv_im = int'(out_im);
    first = 1'b1;
    idx = 0;
    cyc = 0;
    while (idx < N) begin
      bit r;
      @(negedge clk);
      if (first) begin
        check(done == 1'b0, "R7 done lasts one cycle", int'(done), 0, 0, 0);
        first = 1'b0;
      end
      if (junk) check(in_ready == 1'b0, "R3 in_ready low during drain", int'(in_ready), 0, 0, 0);
      if (prev_stall)
        check(out_valid && int'(out_re) == pv_re && int'(out_im) == pv_im,
              "R8 bin held under stall", int'(out_re), int'(out_im), pv_re, pv_im);
      r = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1 && (cyc % 7) != 5);
      cyc++;
      out_ready = r;
      if (r) begin
        check(int'(out_re) == exp_re[idx] && int'(out_im) == exp_im[idx],
              $sformatf("R4/R5/R6 bin %0d", idx), int'(out_re), int'(out_im),
              exp_re[idx], exp_im[idx]);
        idx++;
        prev_stall = 1'b0;
      end else begin
        prev_stall = 1'b1;
        pv_re = int'(out_re);
        pv_im = int'(out_im);
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R2/R8 drain complete, input reopened",
          int'(out_valid), int'(in_ready), 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=(0,0) expected=(1,1)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 state during reset",
          int'(in_ready), int'(out_valid), 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 state after reset",
          int'(in_ready), int'(done), 1, 0);

    // impulse: closed form, every bin equals 64/64 = 1 (R4, R6)
    for (int n = 0; n < N; n++) begin
      src_re[n] = (n == 0) ? 64 : 0;
      src_im[n] = 0;
      exp_re[n] = 1;
      exp_im[n] = 0;
    end
    run_frame(1'b0, 0);

    // ramp with junk loads and stalls
    for (int n = 0; n < N; n++) begin
      src_re[n] = 2 * n - 64;
      src_im[n] = 0;
    end
    compute_ref();
    run_frame(1'b1, 1);

    // complex tone at bin 5 exercises the twiddle table (R5)
    for (int n = 0; n < N; n++) begin
      src_re[n] = rnd(100.0 * $cos(2.0 * PI * 5 * n / N));
      src_im[n] = rnd(100.0 * $sin(2.0 * PI * 5 * n / N));
    end
    compute_ref();
    run_frame(1'b0, 1);

    // pseudo-random full-range samples
    seed = 12345;
    for (int n = 0; n < N; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      src_re[n] = ((seed >> 8) & 255) - 128;
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      src_im[n] = ((seed >> 8) & 255) - 128;
    end
    compute_ref();
    run_frame(1'b1, 1);

    // most negative everywhere: 16-bit wrap corner (R4)
    for (int n = 0; n < N; n++) begin
      src_re[n] = -128;
      src_im[n] = -128;
    end
    compute_ref();
    run_frame(1'b0, 0);

    // alternating extremes
    for (int n = 0; n < N; n++) begin
      src_re[n] = (n % 2 == 0) ? 127 : -127;
      src_im[n] = (n % 3) * 40 - 40;
    end
    compute_ref();
    run_frame(1'b1, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule